// File: doc/BRIEF.md
# Delay-Filter-Permute Pseudo-Chaotic Bit Generator

This block is a discrete-time generator that gives an irregular, reproducible stream of bytes and bits. A 16-bit state register acts as a leaky integrator. On every enabled sample it loses a right-shifted fraction of itself and gains a left-shifted 8-bit value taken from a delay line of depth `DELAY_LEN`. One byte-wide field of the new state is written back into the delay line. Before that value affects the state again, it passes through a fixed-point-free bijective byte table. Because every value in the delay line feeds the state, the state space is large, and the output stays irregular even though every part is simple.

Two identical instances that receive the same enable and coupling stimulus give identical streams. A coupling input can merge an external byte into the value fed back, so that one generator can perturb another. The merge is an average, a modulo-256 sum or an XOR, chosen by parameter. An elaboration option places the table after the delay line or before it. The observable stream is the same either way.

Top module: `dfp_chaos_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes 0, `key_out`, `bit_out` and `valid` become 0, and every delay entry is treated as holding the value 0.
- R2: `valid` is 1 in exactly the cycles that follow a clock edge at which `en` was 1.
- R3: On each edge with `en` high, the state S becomes (S − floor(S/16) + P(u)·32) mod 65536. Here u is the value pushed into the delay line `DELAY_LEN` samples earlier, or 0 if fewer samples have occurred since reset.
- R4: After each sample, `key_out` equals bits [11:4] of the new state and `bit_out` equals bit 0 of the new state.
- R5: The table is P(x) = (77·x + 91) mod 256. It is bijective, has no fixed point and maps 0 to 91. The first sample after reset therefore gives `key_out` = 0xB6 and `bit_out` = 0.
- R6: On an edge with `en` low, the state, delay line, `key_out` and `bit_out` keep their values.
- R7: With `couple_en` high and the averaging merge, the value pushed is (key + `couple_in`) >> 1, computed on 9 bits, where key is the new `key_out`.
- R8: With the sum merge, the value pushed is (key + `couple_in`) mod 256. With the XOR merge, it is key XOR `couple_in`.
- R9: With `couple_en` low, `couple_in` has no effect: the value pushed is the new key itself.
- R10: With the table placed before the delay line, the outputs equal those of the table-after-delay arrangement for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample enable; one sample per high cycle |
| couple_en | input | 1 | Merge `couple_in` into the fed-back value |
| couple_in | input | 8 | External byte for coupling |
| key_out | output | 8 | Registered key byte, state bits [11:4] |
| bit_out | output | 1 | Registered random bit, state bit 0 |
| valid | output | 1 | High the cycle after a sample |

## Verification
The bench builds three instances. Two use a delay length of 8 and one uses a delay length of 5, so the end of the zero-filled start-up window and many wraps of the delay pointer occur within a few hundred cycles. A pointer that does not wrap at a power of two is exercised as well. Each instance uses a different merge (average, XOR, sum), so every merge variant is checked. One instance places the table before the delay line, so its stream is compared with the same behavioural model as the others. The enable and coupling inputs are driven with random patterns, including long idle gaps, and every output is compared each cycle.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  typedef enum logic [1:0] {
    MIX_AVG = 2'd0,
    MIX_ADD = 2'd1,
    MIX_XOR = 2'd2
  } mix_mode_e;
endpackage

// File: rtl/dfp_perm_lut.sv
module dfp_perm_lut #(
  parameter int W   = 8,
  parameter int MUL = 77,
  parameter int ADD = 91
) (
  input  logic [W-1:0] perm_in,
  output logic [W-1:0] perm_out
);
  localparam int TBL_N = 1 << W;

  logic [W-1:0] tbl [TBL_N];

  // Affine map with odd multiplier and odd offset: bijective, no fixed point
  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    assign tbl[i] = W'((MUL * i + ADD) % TBL_N);
  end

  assign perm_out = tbl[perm_in];
endmodule

// File: rtl/dfp_delay_line.sv
module dfp_delay_line #(
  parameter int W        = 8,
  parameter int DEPTH    = 64,
  parameter int FILL_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] fill_q;
  logic             full;

  assign full = (fill_q == CNT_W'(DEPTH));

  // Memory carries no reset so it maps to RAM; the fill count masks stale data
  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (push) begin
      ptr_q  <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      if (!full) fill_q <= fill_q + 1'b1;
    end
  end

  // Read-before-write at the same slot yields the entry pushed DEPTH samples ago
  assign dout = full ? mem[ptr_q] : W'(FILL_VAL);

  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (fill_q == $past(fill_q) + 1'b1));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !push |=> ($stable(ptr_q) && $stable(fill_q)));
endmodule

// File: rtl/dfp_leaky_state.sv
module dfp_leaky_state #(
  parameter int SW     = 16,
  parameter int IW     = 8,
  parameter int LSHIFT = 5,
  parameter int RSHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [IW-1:0] inj,
  output logic [SW-1:0] state_q,
  output logic [SW-1:0] state_nxt
);
  logic [SW:0] leak_w;
  logic [SW:0] gain_w;
  logic [SW:0] sum_w;

  always_comb begin
    leak_w    = {1'b0, state_q >> RSHIFT};
    gain_w    = (SW + 1)'(inj) << LSHIFT;
    sum_w     = {1'b0, state_q} - leak_w + gain_w;
    state_nxt = sum_w[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       state_q <= '0;
    else if (step) state_q <= state_nxt;
  end

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state_q));
endmodule

// File: rtl/dfp_chaos_gen.sv
module dfp_chaos_gen #(
  parameter int                DELAY_LEN   = 64,
  parameter int                SW          = 16,
  parameter int                KW          = 8,
  parameter int                LSHIFT      = 5,
  parameter int                RSHIFT      = 4,
  parameter int                KEY_LSB     = 4,
  parameter int                PERM_MUL    = 77,
  parameter int                PERM_ADD    = 91,
  parameter dfp_pkg::mix_mode_e MIX        = dfp_pkg::MIX_AVG,
  parameter bit                TABLE_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          couple_en,
  input  logic [KW-1:0] couple_in,
  output logic [KW-1:0] key_out,
  output logic          bit_out,
  output logic          valid
);
  localparam int TBL_N    = 1 << KW;
  localparam int FILL_VAL = TABLE_FIRST ? (PERM_ADD % TBL_N) : 0;

  logic [KW-1:0] tap;
  logic [KW-1:0] perm_in;
  logic [KW-1:0] perm_out;
  logic [KW-1:0] inj;
  logic [KW-1:0] local_f;
  logic [KW-1:0] mixed;
  logic [KW-1:0] push_val;
  logic [KW:0]   pair_sum;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_nxt;
  logic [KW-1:0] key_q;
  logic          bit_q;
  logic          valid_q;

  dfp_delay_line #(
    .W(KW), .DEPTH(DELAY_LEN), .FILL_VAL(FILL_VAL)
  ) u_delay (
    .clk(clk), .rst(rst), .push(en), .din(push_val), .dout(tap)
  );

  dfp_perm_lut #(
    .W(KW), .MUL(PERM_MUL), .ADD(PERM_ADD)
  ) u_perm (
    .perm_in(perm_in), .perm_out(perm_out)
  );

  dfp_leaky_state #(
    .SW(SW), .IW(KW), .LSHIFT(LSHIFT), .RSHIFT(RSHIFT)
  ) u_state (
    .clk(clk), .rst(rst), .step(en), .inj(inj),
    .state_q(state_q), .state_nxt(state_nxt)
  );

  assign local_f  = state_nxt[KEY_LSB +: KW];
  assign pair_sum = {1'b0, local_f} + {1'b0, couple_in};

  always_comb begin
    if (!couple_en) begin
      mixed = local_f;
    end else begin
      case (MIX)
        dfp_pkg::MIX_AVG: mixed = pair_sum[KW:1];
        dfp_pkg::MIX_ADD: mixed = pair_sum[KW-1:0];
        default:          mixed = local_f ^ couple_in;
      endcase
    end
  end

  if (TABLE_FIRST) begin : g_table_first
    assign perm_in  = mixed;
    assign push_val = perm_out;
    assign inj      = tap;
  end else begin : g_delay_first
    assign perm_in  = tap;
    assign push_val = mixed;
    assign inj      = perm_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q   <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en;
      if (en) begin
        key_q <= local_f;
        bit_q <= state_nxt[0];
      end
    end
  end

  assign key_out = key_q;
  assign bit_out = bit_q;
  assign valid   = valid_q;

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> valid_q);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid_q);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(key_q) && $stable(bit_q)));

  // R4
  key_state_chk: assert property (@(posedge clk) disable iff (rst)
    (key_q == state_q[KEY_LSB +: KW]) && (bit_q == state_q[0]));

  // R5
  perm_no_fix_chk: assert property (@(posedge clk) disable iff (rst)
    perm_out != perm_in);
endmodule

// File: tb/sim_dfp_chaos_gen.sv
`timescale 1ns/1ps
module sim_dfp_chaos_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, en, couple_en;
  logic [7:0] couple_in;
  logic [7:0] key0, key1, key2;
  logic       bit0, bit1, bit2, vld0, vld1, vld2;

  dfp_chaos_gen #(.DELAY_LEN(8), .MIX(dfp_pkg::MIX_AVG), .TABLE_FIRST(1'b0)) u0 (
    .clk(clk), .rst(rst), .en(en), .couple_en(couple_en), .couple_in(couple_in),
    .key_out(key0), .bit_out(bit0), .valid(vld0));
  dfp_chaos_gen #(.DELAY_LEN(8), .MIX(dfp_pkg::MIX_XOR), .TABLE_FIRST(1'b1)) u1 (
    .clk(clk), .rst(rst), .en(en), .couple_en(couple_en), .couple_in(couple_in),
    .key_out(key1), .bit_out(bit1), .valid(vld1));
  dfp_chaos_gen #(.DELAY_LEN(5), .MIX(dfp_pkg::MIX_ADD), .TABLE_FIRST(1'b0)) u2 (
    .clk(clk), .rst(rst), .en(en), .couple_en(couple_en), .couple_in(couple_in),
    .key_out(key2), .bit_out(bit2), .valid(vld2));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int st[3], cnt[3], ek[3], eb[3];
  int hist[3][64];
  int lens[3]  = '{8, 8, 5};
  int modes[3] = '{0, 2, 1};
  int ev;
  string req;

  function automatic int perm(int x);
    return (77 * x + 91) % 256;
  endfunction

  function automatic int mixv(int m, int a, int b);
    if (m == 0) return (a + b) / 2;
    if (m == 1) return (a + b) % 256;
    return a ^ b;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_step(int k);
    int u, s2, loc, m;
    u   = (cnt[k] < lens[k]) ? 0 : hist[k][(cnt[k] - lens[k]) % 64];
    s2  = (st[k] - (st[k] / 16) + perm(u) * 32) % 65536;
    loc = (s2 / 16) % 256;
    m   = couple_en ? mixv(modes[k], loc, int'(couple_in)) : loc;
    hist[k][cnt[k] % 64] = m;
    cnt[k]++;
    st[k] = s2;
    ek[k] = loc;
    eb[k] = s2 % 2;
  endtask

  task automatic check_all();
    chk(req,   "u0 key",   int'(key0), ek[0]);
    chk("R10", "u1 key",   int'(key1), ek[1]);
    chk("R8",  "u2 key",   int'(key2), ek[2]);
    chk("R4",  "u0 bit",   int'(bit0), eb[0]);
    chk("R10", "u1 bit",   int'(bit1), eb[1]);
    chk("R4",  "u2 bit",   int'(bit2), eb[2]);
    chk("R2",  "u0 valid", int'(vld0), ev);
    chk("R2",  "u1 valid", int'(vld1), ev);
    chk("R2",  "u2 valid", int'(vld2), ev);
  endtask

  task automatic cycle(bit e, bit ce, int ci);
    en        = e;
    couple_en = ce;
    couple_in = 8'(ci);
    if (e) for (int k = 0; k < 3; k++) model_step(k);
    ev = e;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog expired: got 0 expected 1");
    finish_run();
  end

  initial begin
    rst = 1'b1; en = 1'b0; couple_en = 1'b0; couple_in = 8'h00;
    for (int k = 0; k < 3; k++) begin
      st[k] = 0; cnt[k] = 0; ek[k] = 0; eb[k] = 0;
    end
    ev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    req = "R1";
    check_all();
    rst = 1'b0;

    // R5 first sample leaves the all-zero condition
    req = "R5";
    cycle(1'b1, 1'b0, 0);
    chk("R5", "first key 0xB6", int'(key0), 182);

    // R9 coupling input toggles but is disabled
    req = "R9";
    for (int i = 0; i < 150; i++) cycle(1'b1, 1'b0, int'($urandom_range(0, 255)));

    // R6 enable gaps, including long idle runs
    req = "R6";
    for (int i = 0; i < 300; i++)
      cycle(($urandom_range(0, 3) == 0), 1'b0, int'($urandom_range(0, 255)));
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 255);

    // R7 coupled operation with random external bytes
    req = "R7";
    for (int i = 0; i < 400; i++)
      cycle(($urandom_range(0, 4) != 0), ($urandom_range(0, 1) == 1),
            int'($urandom_range(0, 255)));
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1, 255);
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1, 0);

    // R3 long free run across many delay wraps
    req = "R3";
    for (int i = 0; i < 2000; i++) cycle(1'b1, 1'b0, 0);

    // R1 reset in mid-stream restores the start sequence
    rst = 1'b1;
    en  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      st[k] = 0; cnt[k] = 0; ek[k] = 0; eb[k] = 0;
    end
    ev  = 0;
    req = "R1";
    check_all();
    cycle(1'b1, 1'b0, 0);
    chk("R1", "key after second reset", int'(key0), 182);

    finish_run();
  end
endmodule